// File: doc/BRIEF.md
# Machine Cycle Generator and Reset Qualifier

This block sits at the clock root of a small 8-bit controller core. It divides the oscillator clock into machine cycles of twelve oscillator periods and issues a one-clock strobe at the last period of each. The same block turns the raw, active-high reset pin into a clean internal reset for the core.

The pin first passes through a two-flop synchronizer. The internal reset is granted only after the synchronized level has been high for two full machine cycles (24 consecutive oscillator periods). Shorter pulses are discarded, and any low sample restarts the qualification count.

Once granted, the internal reset holds for as long as the synchronized pin stays high. It is withdrawn only at a machine-cycle boundary, so the first cycle after release starts at phase 0. The block also presents the reset values that the core registers take while the internal reset is high. These are the program counter, accumulator, B register, status word, stack pointer and data pointer.

Top module: `mcycle_rst_ctrl`

## Requirements
- R1: While running, `mc_strobe_o` is high for exactly one clock in every 12 clocks, with 11 low clocks between consecutive strobes.
- R2: The pin reaches the qualifier through two flops. A pin pulse of exactly 24 clocks is therefore accepted, and `core_rst_o` rises on the 26th rising edge after the pin rises.
- R3: If the pin is held high for 24 clocks or more, `core_rst_o` rises on the 26th rising edge after the pin goes high. It is independent of the machine-cycle phase.
- R4: A pin pulse shorter than 24 clocks leaves `core_rst_o` low. A single low sample restarts the count, so two 20-clock pulses separated by one low clock also leave it low.
- R5: `core_rst_o` stays high on every clock for as long as the synchronized pin stays high.
- R6: `core_rst_o` falls only at the edge that ends a strobe clock, at the first such edge at which the synchronized pin is low.
- R7: After `core_rst_o` falls, the machine-cycle phase is 0, so the next strobe is observed 11 clocks after the fall is observed.
- R8: The reset-value outputs are: program counter 0x0000, accumulator 0x00, B 0x00, status word 0x00, stack pointer 0x07, data pointer 0x0000.
- R9: From power-up, `core_rst_o` is low and the first strobe occurs in the 12th oscillator period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock |
| rst_pin_i | input | 1 | Raw asynchronous reset pin, active high |
| mc_strobe_o | output | 1 | One-clock strobe in the last period of each machine cycle |
| core_rst_o | output | 1 | Qualified, synchronous internal reset |
| pc_init_o | output | 16 | Reset value of the program counter |
| acc_init_o | output | 8 | Reset value of the accumulator |
| b_init_o | output | 8 | Reset value of the B register |
| psw_init_o | output | 8 | Reset value of the status word |
| sp_init_o | output | 8 | Reset value of the stack pointer |
| dptr_init_o | output | 16 | Reset value of the data pointer |

## Verification
The hardest situation to reach is a pulse that sits one clock either side of the qualification threshold, together with a pulse train whose total high time exceeds the threshold while no single run does. The stimulus drives pulses of exactly 23 and 24 clocks, then two 20-clock pulses split by a single low clock. The release path is a second hard case, because the fall must line up with a strobe that the pin does not control. To cover it, the stimulus drops the pin at several different phases and compares every clock against a behavioural model.

// File: rtl/mcycle_pkg.sv
package mcycle_pkg;
    localparam int unsigned CYC_CLKS_DEF    = 12;
    localparam int unsigned QUAL_CYCLES_DEF = 2;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    localparam logic [15:0] PC_RST_DEF   = 16'h0000;
    localparam logic [7:0]  ACC_RST_DEF  = 8'h00;
    localparam logic [7:0]  B_RST_DEF    = 8'h00;
    localparam logic [7:0]  PSW_RST_DEF  = 8'h00;
    localparam logic [7:0]  SP_RST_DEF   = 8'h07;
    localparam logic [15:0] DPTR_RST_DEF = 16'h0000;
endpackage

// File: rtl/mcycle_sync.sv
module mcycle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d;
    sync_state_t st_q = '0;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/mcycle_phase.sv
module mcycle_phase #(
    parameter int unsigned CYC_CLKS = 12
) (
    input  logic clk_i,
    input  logic restart_i,
    output logic strobe_o
);
    localparam int unsigned PW = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CYC_CLKS - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } phase_state_t;

    phase_state_t st_d;
    phase_state_t st_q = '0;

    always_comb begin
        st_d = st_q;
        if (restart_i || st_q.phase == LAST) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign strobe_o = (st_q.phase == LAST);
endmodule

// File: rtl/mcycle_qual.sv
module mcycle_qual #(
    parameter int unsigned QUAL_CLKS = 24
) (
    input  logic clk_i,
    input  logic level_i,
    input  logic boundary_i,
    output logic active_o,
    output logic release_o
);
    localparam int unsigned CW = $clog2(QUAL_CLKS + 1);
    localparam logic [CW-1:0] FULL = CW'(QUAL_CLKS);
    localparam logic [CW-1:0] ARM  = CW'(QUAL_CLKS - 1);

    typedef struct packed {
        logic [CW-1:0] run;
        logic          active;
    } qual_state_t;

    qual_state_t st_d;
    qual_state_t st_q = '0;
    logic        rel;

    always_comb begin
        st_d = st_q;
        rel  = st_q.active && !level_i && boundary_i;
        if (!level_i) begin
            st_d.run = '0;
        end else if (st_q.run != FULL) begin
            st_d.run = st_q.run + 1'b1;
        end
        if (st_q.active) begin
            st_d.active = !rel;
        end else begin
            st_d.active = level_i && (st_q.run >= ARM);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign active_o  = st_q.active;
    assign release_o = rel;
endmodule

// File: rtl/mcycle_rst_ctrl.sv
module mcycle_rst_ctrl
    import mcycle_pkg::*;
#(
    parameter int unsigned CYC_CLKS    = CYC_CLKS_DEF,
    parameter int unsigned QUAL_CYCLES = QUAL_CYCLES_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    parameter logic [15:0] PC_RST      = PC_RST_DEF,
    parameter logic [7:0]  ACC_RST     = ACC_RST_DEF,
    parameter logic [7:0]  B_RST       = B_RST_DEF,
    parameter logic [7:0]  PSW_RST     = PSW_RST_DEF,
    parameter logic [7:0]  SP_RST      = SP_RST_DEF,
    parameter logic [15:0] DPTR_RST    = DPTR_RST_DEF
) (
    input  logic        osc_clk_i,
    input  logic        rst_pin_i,
    output logic        mc_strobe_o,
    output logic        core_rst_o,
    output logic [15:0] pc_init_o,
    output logic [7:0]  acc_init_o,
    output logic [7:0]  b_init_o,
    output logic [7:0]  psw_init_o,
    output logic [7:0]  sp_init_o,
    output logic [15:0] dptr_init_o
);
    localparam int unsigned QUAL_CLKS = QUAL_CYCLES * CYC_CLKS;

    logic pin_sync;
    logic strobe;
    logic release_evt;
    logic rst_active;

    mcycle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (osc_clk_i),
        .async_i (rst_pin_i),
        .sync_o  (pin_sync)
    );

    mcycle_phase #(.CYC_CLKS(CYC_CLKS)) u_phase (
        .clk_i     (osc_clk_i),
        .restart_i (release_evt),
        .strobe_o  (strobe)
    );

    mcycle_qual #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
        .clk_i      (osc_clk_i),
        .level_i    (pin_sync),
        .boundary_i (strobe),
        .active_o   (rst_active),
        .release_o  (release_evt)
    );

    assign mc_strobe_o = strobe;
    assign core_rst_o  = rst_active;
    assign pc_init_o   = PC_RST;
    assign acc_init_o  = ACC_RST;
    assign b_init_o    = B_RST;
    assign psw_init_o  = PSW_RST;
    assign sp_init_o   = SP_RST;
    assign dptr_init_o = DPTR_RST;
endmodule

// File: rtl/mcycle_rst_ctrl_chk.sv
module mcycle_rst_ctrl_chk #(
    parameter int unsigned CYC_CLKS    = 12,
    parameter int unsigned QUAL_CYCLES = 2
) (
    input logic osc_clk_i,
    input logic rst_pin_i,
    input logic mc_strobe_o,
    input logic core_rst_o,
    input logic pin_sync
);
    localparam int unsigned QCLK = QUAL_CYCLES * CYC_CLKS;
    localparam int unsigned GW   = $clog2(CYC_CLKS) + 1;
    localparam int unsigned RW   = $clog2(QCLK + 1) + 1;

    logic          armed   = 1'b0;
    logic [GW-1:0] gap     = '0;
    logic [RW-1:0] pin_run = '0;

    always_ff @(posedge osc_clk_i) begin
        armed <= 1'b1;
        gap   <= mc_strobe_o ? '0 : gap + 1'b1;
        if (!rst_pin_i) begin
            pin_run <= '0;
        end else if (pin_run != RW'(QCLK)) begin
            pin_run <= pin_run + 1'b1;
        end
    end

    // R1: strobe arrives exactly CYC_CLKS clocks after the previous one
    assert_strobe_period_R1: assert property (@(posedge osc_clk_i) disable iff (!armed)
        mc_strobe_o |-> gap == GW'(CYC_CLKS - 1));

    // R1: strobe never lasts two clocks
    assert_strobe_single_R1: assert property (@(posedge osc_clk_i) disable iff (!armed)
        mc_strobe_o |=> !mc_strobe_o);

    // R3: internal reset only after a long enough raw pulse
    assert_rise_qualified_R3: assert property (@(posedge osc_clk_i) disable iff (!armed)
        $rose(core_rst_o) |-> $past(pin_run, 2) >= RW'(QCLK));

    // R5: held while synchronized pin high
    assert_hold_R5: assert property (@(posedge osc_clk_i) disable iff (!armed)
        (core_rst_o && pin_sync) |=> core_rst_o);

    // R6: release only at a boundary with the pin low
    assert_release_boundary_R6: assert property (@(posedge osc_clk_i) disable iff (!armed)
        $fell(core_rst_o) |-> ($past(mc_strobe_o) && !$past(pin_sync)));
endmodule

bind mcycle_rst_ctrl mcycle_rst_ctrl_chk #(
    .CYC_CLKS    (CYC_CLKS),
    .QUAL_CYCLES (QUAL_CYCLES)
) u_chk (
    .osc_clk_i   (osc_clk_i),
    .rst_pin_i   (rst_pin_i),
    .mc_strobe_o (mc_strobe_o),
    .core_rst_o  (core_rst_o),
    .pin_sync    (pin_sync)
);

// File: tb/mcycle_rst_ctrl_tb.sv
module mcycle_rst_ctrl_tb;
    logic        clk = 1'b0;
    logic        pin = 1'b0;
    logic        strobe, crst;
    logic [15:0] pc_v, dptr_v;
    logic [7:0]  acc_v, b_v, psw_v, sp_v;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    mcycle_rst_ctrl u_dut (
        .osc_clk_i   (clk),
        .rst_pin_i   (pin),
        .mc_strobe_o (strobe),
        .core_rst_o  (crst),
        .pc_init_o   (pc_v),
        .acc_init_o  (acc_v),
        .b_init_o    (b_v),
        .psw_init_o  (psw_v),
        .sp_init_o   (sp_v),
        .dptr_init_o (dptr_v)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_phase = 0;
    int m_run   = 0;
    bit m_act   = 0;
    bit m_s1    = 0;
    bit m_s2    = 0;
    bit m_on    = 1;

    always @(posedge clk) begin
        bit rel;
        rel     = m_act && !m_s2 && (m_phase == 11);
        m_phase = (m_phase == 11 || rel) ? 0 : m_phase + 1;
        if (m_act) m_act = !rel;
        else       m_act = m_s2 && (m_run >= 23);
        m_run   = m_s2 ? ((m_run < 24) ? m_run + 1 : 24) : 0;
        m_s2    = m_s1;
        m_s1    = pin;
    end

    always @(negedge clk) begin
        if (m_on && !done) begin
            check(strobe == (m_phase == 11), "R1 strobe vs model", strobe, m_phase == 11);
            check(crst == m_act, "R5 core reset vs model", crst, m_act);
        end
    end

    // drive pin high for len clocks; return negedge index where reset first seen
    task automatic pulse(input int len, input int span, output int lat);
        lat = 0;
        @(negedge clk);
        pin = 1'b1;
        for (int i = 1; i <= span; i++) begin
            @(negedge clk);
            if (crst && lat == 0) lat = i;
            if (i == len) pin = 1'b0;
        end
        pin = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // wait for release, then measure clocks to next strobe
    task automatic watch_release(input string tag);
        bit prev_s;
        bit prev_r;
        int k;
        prev_s = strobe;
        prev_r = crst;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (prev_r && !crst) begin
                check(prev_s == 1'b1, {tag, " R6 fall follows strobe"}, prev_s, 1);
                k = 0;
                while (!strobe && k < 40) begin
                    @(negedge clk);
                    k++;
                end
                check(k == 11, {tag, " R7 phase restart"}, k, 11);
                return;
            end
            prev_s = strobe;
            prev_r = crst;
        end
        check(1'b0, {tag, " R6 release seen"}, 0, 1);
    endtask

    initial begin
        int lat;
        int k;
        int hi;
        #1;
        check(crst == 1'b0, "R9 reset low at power-up", crst, 0);
        check(strobe == 1'b0, "R9 no strobe at power-up", strobe, 0);
        check(pc_v == 16'h0000, "R8 pc", pc_v, 0);
        check(acc_v == 8'h00, "R8 acc", acc_v, 0);
        check(b_v == 8'h00, "R8 b", b_v, 0);
        check(psw_v == 8'h00, "R8 psw", psw_v, 0);
        check(sp_v == 8'h07, "R8 sp", sp_v, 8'h07);
        check(dptr_v == 16'h0000, "R8 dptr", dptr_v, 0);

        k = 0;
        while (!strobe && k < 40) begin
            @(negedge clk);
            k++;
        end
        check(k == 11, "R9 first strobe in 12th period", k, 11);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!strobe && k < 40);
        check(k == 12, "R1 strobe spacing", k, 12);

        pulse(23, 60, lat);
        check(lat == 0, "R4 23-clock pulse ignored", lat, 0);
        idle(5);

        @(negedge clk); pin = 1'b1;
        idle(20);
        pin = 1'b0;
        @(negedge clk); pin = 1'b1;
        idle(20);
        pin = 1'b0;
        idle(40);
        check(crst == 1'b0, "R4 split pulses restart count", crst, 0);

        pulse(24, 26, lat);
        check(lat == 26, "R2 exact 24-clock pulse accepted", lat, 26);
        watch_release("p24");
        idle(7);

        pulse(30, 30, lat);
        check(lat == 26, "R3 latency 26 edges", lat, 26);
        watch_release("p30");
        idle(3);

        @(negedge clk); pin = 1'b1;
        idle(30);
        hi = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!crst) hi = 0;
        end
        check(hi == 1, "R5 held while pin high", hi, 1);
        pin = 1'b0;
        watch_release("long");

        for (int off = 0; off < 5; off++) begin
            idle(off * 5 + 1);
            pulse(25 + off * 3, 25 + off * 3, lat);
            check(lat == 26 || (lat == 0 && 25 + off * 3 < 26), "R3 varied phase", lat, 26);
            watch_release("var");
        end

        idle(30);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule